// File: doc/BRIEF.md
# Masked Vector Execution Lane

This block runs one arithmetic operation across the elements of two source vectors and writes the results into a destination vector register that it holds internally. A per-element mask register controls which elements are written. Two compare operations produce the mask. A third operation inverts the mask, so a two-way select can be built from a compare, a masked copy of one source, a complement, and a masked copy of the other source.

Element operations run in one of two schedules. In the full-sweep schedule, the lane visits every element below the vector length, one per cycle, and the mask only enables the write. In the density-time schedule, the lane captures the active mask bits when the command is accepted. On each cycle it takes the lowest remaining active element and issues only that one, so the run time follows the number of active elements. Both schedules leave the same destination contents.

Source vectors are read from the input ports while a command runs. The caller holds them steady from the start pulse until done.

Top module: `vlane_masked_exec`

## Requirements
- R1: After synchronous reset, the mask, every destination element, busy and done are all zero.
- R2: Op code 6 (nonzero test) sets mask bit i to (a[i] != 0) for every i below the vector length and clears every mask bit at or above it. It completes in one cycle.
- R3: Op code 5 (greater-or-equal test) sets mask bit i to (a[i] >= b[i]) for i below the vector length, comparing elements as two's-complement signed values. It clears the mask bits at or above the vector length and completes in one cycle.
- R4: Op code 7 inverts the mask bits below the vector length, leaves the bits at or above it unchanged, and completes in one cycle.
- R5: With dense_i = 0, an element op takes max(1, L) cycles, where L is the vector length. It writes element i only when i < L and mask bit i is 1.
- R6: With dense_i = 1, an element op takes max(1, P) cycles, where P is the number of set mask bits below the vector length. Each of those cycles writes one active element, and the final destination equals the one the full-sweep schedule produces.
- R7: The element op codes are 0 = a+b, 1 = a-b, 2 = low EW bits of a*b, 3 = copy a, and 4 = copy b. All results wrap modulo 2^EW.
- R8: Mask bits at or above the vector length have no effect on element ops. Destination elements at or above the vector length keep their values. A vector length above NELEM acts as NELEM.
- R9: busy is high from the cycle after an accepted start until done. done is a one-cycle pulse during which busy is low.
- R10: A start pulse that arrives while busy is ignored. The running command keeps its op, length and cycle count.
- R11: Running op 5, then op 3, then op 7, then op 4, all at full length, leaves dst[i] equal to the signed maximum of a[i] and b[i].
- R12: The destination changes only while busy. The mask changes only at the edge that completes a mask op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command start pulse, accepted when idle |
| op_i | input | 3 | Operation code |
| dense_i | input | 1 | 1 = density-time schedule, 0 = full sweep |
| vlen_i | input | VLW | Vector length for the command |
| a_vec_i | input | NELEM*EW | Source vector A, element i at bits [i*EW +: EW] |
| b_vec_i | input | NELEM*EW | Source vector B, same layout |
| busy_o | output | 1 | A command is running |
| done_o | output | 1 | One-cycle completion pulse |
| mask_o | output | NELEM | Current mask register |
| dst_vec_o | output | NELEM*EW | Destination register, same layout as the sources |

## Verification
The start pulse is sampled at one clock edge. Each following edge processes one element, or it performs the whole mask update for a mask op. done appears after the edge that handles the last work item, so a command spans max(1, work) edges, where work is L for a sweep and P for density-time. The bench counts edges from the accepting edge until it sees done at a falling edge, and compares that count with the value its model computes from the mask and length. It reads the mask and destination only at that falling edge. It also checks that done has dropped one cycle later. Checks of the idle state are made after several quiet cycles during which the source inputs keep changing.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MUL   = 3'd2,
        OP_CPYA  = 3'd3,
        OP_CPYB  = 3'd4,
        OP_CMPGE = 3'd5,
        OP_CMPNZ = 3'd6,
        OP_MNOT  = 3'd7
    } vop_e;

    typedef struct packed {
        logic fire;   // a work cycle is being spent
        logic act;    // this cycle writes an element
        logic last;   // this cycle completes the command
    } issue_t;

    function automatic logic is_mask_op(vop_e op);
        return (op == OP_CMPGE) || (op == OP_CMPNZ) || (op == OP_MNOT);
    endfunction

endpackage

// File: rtl/vlane_elem_alu.sv
module vlane_elem_alu
    import vlane_pkg::*;
#(
    parameter int EW = 8
) (
    input  vop_e          op_i,
    input  logic [EW-1:0] a_i,
    input  logic [EW-1:0] b_i,
    output logic [EW-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_ADD:  res_o = a_i + b_i;
            OP_SUB:  res_o = a_i - b_i;
            OP_MUL:  res_o = EW'(a_i * b_i);
            OP_CPYA: res_o = a_i;
            OP_CPYB: res_o = b_i;
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/vlane_mask_unit.sv
module vlane_mask_unit
    import vlane_pkg::*;
#(
    parameter int NELEM = 8,
    parameter int EW    = 8,
    parameter int VLW   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  vop_e                op_i,
    input  logic [VLW-1:0]      vlen_i,
    input  logic [NELEM*EW-1:0] a_vec_i,
    input  logic [NELEM*EW-1:0] b_vec_i,
    output logic [NELEM-1:0]    mask_o
);
    logic [NELEM-1:0] mask_q;
    logic [NELEM-1:0] mask_d;

    for (genvar g = 0; g < NELEM; g++) begin : g_bit
        logic [EW-1:0] ea;
        logic [EW-1:0] eb;
        logic          inlen;
        logic          ge;
        logic          nz;
        assign ea    = a_vec_i[g*EW +: EW];
        assign eb    = b_vec_i[g*EW +: EW];
        assign inlen = (vlen_i > VLW'(g));
        assign ge    = ($signed(ea) >= $signed(eb));
        assign nz    = |ea;
        always_comb begin
            unique case (op_i)
                OP_CMPGE: mask_d[g] = inlen & ge;
                OP_CMPNZ: mask_d[g] = inlen & nz;
                OP_MNOT:  mask_d[g] = inlen ? ~mask_q[g] : mask_q[g];
                default:  mask_d[g] = mask_q[g];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '0;
        else if (wr_i) mask_q <= mask_d;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/vlane_sched.sv
module vlane_sched
    import vlane_pkg::*;
#(
    parameter int NELEM = 8,
    parameter int VLW   = 4,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic             dense_i,
    input  logic             single_i,
    input  logic [VLW-1:0]   vlen_i,
    input  logic [NELEM-1:0] mask_i,
    output logic             busy_o,
    output logic [VLW-1:0]   vlen_o,
    output logic [IW-1:0]    idx_o,
    output issue_t           issue_o
);
    logic             busy_q;
    logic             dense_q;
    logic             single_q;
    logic [VLW-1:0]   vlen_q;
    logic [IW-1:0]    cnt_q;
    logic [NELEM-1:0] pend_q;
    logic [NELEM-1:0] lm_in;
    logic [NELEM-1:0] clr;
    logic [NELEM-1:0] pend_nx;
    logic [IW-1:0]    pick;
    logic             found;
    logic             sweep_act;
    logic             last;

    for (genvar g = 0; g < NELEM; g++) begin : g_lm
        assign lm_in[g] = (vlen_i > VLW'(g));
    end

    // lowest remaining active element
    always_comb begin
        pick = '0;
        for (int i = NELEM - 1; i >= 0; i--) begin
            if (pend_q[i]) pick = IW'(i);
        end
        found = |pend_q;
    end

    always_comb begin
        clr       = '0;
        clr[pick] = 1'b1;
    end

    assign pend_nx   = pend_q & ~clr;
    assign sweep_act = mask_i[cnt_q] && (VLW'(cnt_q) < vlen_q);

    always_comb begin
        if (single_q)     last = 1'b1;
        else if (dense_q) last = (pend_nx == '0);
        else              last = (vlen_q == '0) || (VLW'(cnt_q) == vlen_q - VLW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            dense_q  <= 1'b0;
            single_q <= 1'b0;
            vlen_q   <= '0;
            cnt_q    <= '0;
            pend_q   <= '0;
        end else if (accept_i) begin
            busy_q   <= 1'b1;
            dense_q  <= dense_i;
            single_q <= single_i;
            vlen_q   <= vlen_i;
            cnt_q    <= '0;
            pend_q   <= mask_i & lm_in;
        end else if (busy_q) begin
            if (last) busy_q <= 1'b0;
            cnt_q  <= cnt_q + IW'(1);
            pend_q <= pend_nx;
        end
    end

    assign busy_o       = busy_q;
    assign vlen_o       = vlen_q;
    assign idx_o        = dense_q ? pick : cnt_q;
    assign issue_o.fire = busy_q;
    assign issue_o.act  = busy_q && !single_q && (dense_q ? found : sweep_act);
    assign issue_o.last = busy_q && last;
endmodule

// File: rtl/vlane_dst_reg.sv
module vlane_dst_reg #(
    parameter int NELEM = 8,
    parameter int EW    = 8,
    parameter int IW    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we_i,
    input  logic [IW-1:0]       idx_i,
    input  logic [EW-1:0]       data_i,
    output logic [NELEM-1:0]    we_vec_o,
    output logic [NELEM*EW-1:0] dst_o
);
    for (genvar g = 0; g < NELEM; g++) begin : g_el
        logic [EW-1:0] el_q;
        assign we_vec_o[g] = we_i && (idx_i == IW'(g));
        always_ff @(posedge clk) begin
            if (rst)              el_q <= '0;
            else if (we_vec_o[g]) el_q <= data_i;
        end
        assign dst_o[g*EW +: EW] = el_q;
    end
endmodule

// File: rtl/vlane_masked_exec.sv
module vlane_masked_exec
    import vlane_pkg::*;
#(
    parameter int NELEM = 8,
    parameter int EW    = 8,
    parameter int VLW   = $clog2(NELEM + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [2:0]          op_i,
    input  logic                dense_i,
    input  logic [VLW-1:0]      vlen_i,
    input  logic [NELEM*EW-1:0] a_vec_i,
    input  logic [NELEM*EW-1:0] b_vec_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [NELEM-1:0]    mask_o,
    output logic [NELEM*EW-1:0] dst_vec_o
);
    localparam int IW = (NELEM > 1) ? $clog2(NELEM) : 1;

    logic           busy_w;
    logic           accept;
    logic [VLW-1:0] vlen_c;
    logic [VLW-1:0] vlen_run;
    logic [IW-1:0]  idx;
    issue_t         issue;
    vop_e           op_q;
    logic           done_q;
    logic [EW-1:0]  res;
    logic [NELEM-1:0] elem_we;
    logic [NELEM-1:0] mask_w;

    assign accept = start_i && !busy_w;
    assign vlen_c = (vlen_i > VLW'(NELEM)) ? VLW'(NELEM) : vlen_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_ADD;
            done_q <= 1'b0;
        end else begin
            if (accept) op_q <= vop_e'(op_i);
            done_q <= issue.last;
        end
    end

    vlane_sched #(.NELEM(NELEM), .VLW(VLW), .IW(IW)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .dense_i  (dense_i),
        .single_i (is_mask_op(vop_e'(op_i))),
        .vlen_i   (vlen_c),
        .mask_i   (mask_w),
        .busy_o   (busy_w),
        .vlen_o   (vlen_run),
        .idx_o    (idx),
        .issue_o  (issue)
    );

    vlane_mask_unit #(.NELEM(NELEM), .EW(EW), .VLW(VLW)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (issue.fire && is_mask_op(op_q)),
        .op_i    (op_q),
        .vlen_i  (vlen_run),
        .a_vec_i (a_vec_i),
        .b_vec_i (b_vec_i),
        .mask_o  (mask_w)
    );

    vlane_elem_alu #(.EW(EW)) u_alu (
        .op_i  (op_q),
        .a_i   (a_vec_i[idx*EW +: EW]),
        .b_i   (b_vec_i[idx*EW +: EW]),
        .res_o (res)
    );

    vlane_dst_reg #(.NELEM(NELEM), .EW(EW), .IW(IW)) u_dst (
        .clk      (clk),
        .rst      (rst),
        .we_i     (issue.act),
        .idx_i    (idx),
        .data_i   (res),
        .we_vec_o (elem_we),
        .dst_o    (dst_vec_o)
    );

    assign busy_o = busy_w;
    assign done_o = done_q;
    assign mask_o = mask_w;
endmodule

// File: rtl/vlane_masked_exec_chk.sv
module vlane_masked_exec_chk #(
    parameter int NELEM = 8,
    parameter int EW    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                start_i,
    input logic                busy_i,
    input logic                done_i,
    input logic [NELEM-1:0]    mask_i,
    input logic [NELEM*EW-1:0] dst_i,
    input logic [NELEM-1:0]    we_i
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_i |=> !done_i);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done_i |-> !busy_i);

    p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_i) |=> busy_i);

    p_one_write_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_i));

    p_dst_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !busy_i |=> $stable(dst_i));

    p_mask_edge_r12: assert property (@(posedge clk) disable iff (rst)
        !$stable(mask_i) |-> done_i);
endmodule

bind vlane_masked_exec vlane_masked_exec_chk #(.NELEM(NELEM), .EW(EW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_i  (busy_o),
    .done_i  (done_o),
    .mask_i  (mask_o),
    .dst_i   (dst_vec_o),
    .we_i    (elem_we)
);

// File: tb/tb_vlane_masked_exec.sv
module tb_vlane_masked_exec;
    localparam int NE = 8;
    localparam int EW = 8;
    localparam int VLW = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [2:0]        op_i = 3'd0;
    logic              dense_i = 1'b0;
    logic [VLW-1:0]    vlen_i = '0;
    logic [NE*EW-1:0]  a_vec_i = '0;
    logic [NE*EW-1:0]  b_vec_i = '0;
    logic              busy_o;
    logic              done_o;
    logic [NE-1:0]     mask_o;
    logic [NE*EW-1:0]  dst_vec_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] am [NE];
    logic [7:0] bm [NE];
    logic [7:0] dm [NE];
    logic [NE-1:0] mm;

    always #2 clk = ~clk;

    vlane_masked_exec #(.NELEM(NE), .EW(EW)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .dense_i(dense_i),
        .vlen_i(vlen_i), .a_vec_i(a_vec_i), .b_vec_i(b_vec_i), .busy_o(busy_o),
        .done_o(done_o), .mask_o(mask_o), .dst_vec_o(dst_vec_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pack_dm();
        logic [63:0] v;
        for (int i = 0; i < NE; i++) v[i*8 +: 8] = dm[i];
        return v;
    endfunction

    task automatic drive_src();
        for (int i = 0; i < NE; i++) begin
            a_vec_i[i*8 +: 8] = am[i];
            b_vec_i[i*8 +: 8] = bm[i];
        end
    endtask

    function automatic logic [7:0] elem_f(input int op, input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = a * b;
        case (op)
            0: return a + b;
            1: return a - b;
            2: return p[7:0];
            3: return a;
            default: return b;
        endcase
    endfunction

    // model update and expected cycle count
    task automatic model(input int op, input bit dn, input int vl, output int cyc);
        int vle;
        int cnt;
        vle = (vl > NE) ? NE : vl;
        cnt = 0;
        for (int i = 0; i < vle; i++) if (mm[i]) cnt++;
        if (op >= 5)  cyc = 1;
        else if (dn)  cyc = (cnt == 0) ? 1 : cnt;
        else          cyc = (vle == 0) ? 1 : vle;
        for (int i = 0; i < NE; i++) begin
            if (op == 5)      mm[i] = (i < vle) && ($signed(am[i]) >= $signed(bm[i]));
            else if (op == 6) mm[i] = (i < vle) && (am[i] != 8'd0);
            else if (op == 7) mm[i] = (i < vle) ? ~mm[i] : mm[i];
            else if (i < vle && mm[i]) dm[i] = elem_f(op, am[i], bm[i]);
        end
    endtask

    task automatic run(input int op, input bit dn, input int vl, input string t_lat, input string t_val);
        int exp_cyc;
        int cyc;
        bit bz;
        model(op, dn, vl, exp_cyc);
        @(negedge clk);
        op_i = 3'(op); dense_i = dn; vlen_i = VLW'(vl); start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        bz = busy_o;
        cyc = 0;
        while (1) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (done_o || cyc > 40) break;
        end
        chk(cyc == exp_cyc, t_lat, 64'(cyc), 64'(exp_cyc));
        chk(bz == 1'b1, "R9", 64'(bz), 64'd1);
        chk(busy_o == 1'b0, "R9", 64'(busy_o), 64'd0);
        chk(mask_o == mm, t_val, 64'(mask_o), 64'(mm));
        chk(dst_vec_o == pack_dm(), t_val, dst_vec_o, pack_dm());
        @(negedge clk);
        chk(done_o == 1'b0, "R9", 64'(done_o), 64'd0);
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got %0h expected %0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cyc_x;
        for (int i = 0; i < NE; i++) begin am[i] = 0; bm[i] = 0; dm[i] = 0; end
        mm = '0;
        drive_src();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(mask_o == '0, "R1", 64'(mask_o), 0);
        chk(dst_vec_o == '0, "R1", dst_vec_o, 0);
        chk(!busy_o && !done_o, "R1", 64'({busy_o, done_o}), 0);

        // sweep over all mask patterns
        for (int p = 0; p < 256; p++) begin
            int vm;
            int ve;
            for (int i = 0; i < NE; i++) begin
                am[i] = p[i] ? (8'(i * 29 + p) | 8'h01) : 8'h00;
                bm[i] = 8'(p * 3 + i * 11 + 7);
            end
            drive_src();
            vm = (p % 3 == 0) ? 5 : 8;
            ve = (p % 4 == 0) ? 3 : ((p % 4 == 1) ? 8 : ((p % 4 == 2) ? 0 : 6));
            run(6, p[1], vm, "R2", "R2");
            if (p % 7 == 0) run(7, 1'b0, (p % 2 == 0) ? 4 : 8, "R4", "R4");
            run(p % 5, 1'b0, ve, "R5", (ve < 8) ? "R8" : "R7");
            run((p + 2) % 5, 1'b1, ve, "R6", (ve < 8) ? "R8" : "R7");
        end

        // R3 signed compare and R11 select sequence
        am[0] = 8'd1;   bm[0] = 8'd2;
        am[1] = 8'd2;   bm[1] = 8'd2;
        am[2] = 8'hFB;  bm[2] = 8'hFC;
        am[3] = 8'h7F;  bm[3] = 8'h80;
        am[4] = 8'h80;  bm[4] = 8'h7F;
        am[5] = 8'd0;   bm[5] = 8'hFD;
        am[6] = 8'hF9;  bm[6] = 8'hF8;
        am[7] = 8'd10;  bm[7] = 8'd40;
        drive_src();
        run(5, 1'b0, 8, "R3", "R3");
        chk(mask_o == 8'b0110_1010, "R3", 64'(mask_o), 64'h6a);
        run(3, 1'b1, 8, "R6", "R11");
        run(7, 1'b0, 8, "R4", "R4");
        run(4, 1'b0, 8, "R5", "R11");
        for (int i = 0; i < NE; i++) begin
            logic [7:0] mx;
            mx = ($signed(am[i]) >= $signed(bm[i])) ? am[i] : bm[i];
            chk(dst_vec_o[i*8 +: 8] == mx, "R11", 64'(dst_vec_o[i*8 +: 8]), 64'(mx));
        end

        // R8 over-long length acts as NELEM
        run(6, 1'b0, 12, "R2", "R8");
        run(0, 1'b1, 15, "R6", "R8");

        // R10 start while busy is ignored
        run(6, 1'b0, 8, "R2", "R2");
        model(0, 1'b0, 8, cyc_x);
        @(negedge clk);
        op_i = 3'd0; dense_i = 1'b0; vlen_i = 4'd8; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        op_i = 3'd7; vlen_i = 4'd2; dense_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        begin
            int c;
            c = 3;
            while (!done_o && c < 40) begin @(negedge clk); c++; end
            chk(c == 9, "R10", 64'(c), 64'd9);
        end
        chk(mask_o == mm, "R10", 64'(mask_o), 64'(mm));
        chk(dst_vec_o == pack_dm(), "R10", dst_vec_o, pack_dm());

        // R12 idle outputs hold while sources move
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            a_vec_i = {8{8'(k * 17 + 3)}};
            b_vec_i = {8{8'(k * 5 + 1)}};
        end
        chk(dst_vec_o == pack_dm(), "R12", dst_vec_o, pack_dm());
        chk(mask_o == mm, "R12", 64'(mask_o), 64'(mm));

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule